// File: doc/BRIEF.md
# Stereo Volume Attenuator with Synchronized Load

This block is a two-channel digital volume control. A 16-bit control word, qualified by a strobe, picks a channel register by address and writes an 8-bit attenuation code into that channel's staging register. The word may also carry a load flag.

When a valid word has the load flag set, the staged codes of both channels are copied into the active gain registers on the same clock edge. The other channel's staged code is moved at that edge even if it was written earlier without a load. This lets software stage the left and right levels one at a time, then apply them together.

Each channel multiplies a signed 16-bit PCM sample by its active code, divided by 256. The top code is exact unity gain. The result is registered one cycle after the sample strobe.

Top module: `stereo_vol_atten`

## Requirements
- R1: After reset, both the staged and active codes are FFh, `out_valid` is 0 and both outputs are 0.
- R2: A valid word with the load flag (bit 8) at 0 updates only the staged code of the addressed channel. The gain applied to samples does not change.
- R3: A valid word with the load flag at 1 writes its code into the addressed staging register. On the same edge it copies both channels' staged codes into their active codes.
- R4: Bits 10:9 select the channel: value 0 selects left and value 1 selects right. Bits 7:0 are the code, with bit 7 as the MSB.
- R5: A word with any of bits 15:11 set, or with an address value of 2 or 3, is ignored. It changes no staged code and no active code, even when its load flag is set.
- R6: For codes 00h to FEh the output is the sample times the code, shifted right arithmetically by 8. This rounds toward negative infinity.
- R7: Code 00h gives an output of exactly 0.
- R8: Code FFh passes the sample through unchanged.
- R9: `out_valid` is `in_valid` delayed by one cycle. The outputs update only on the cycle after a valid sample and hold their value otherwise.
- R10: A sample presented in the same cycle as a committing word is scaled with the previous active codes. Samples presented after that cycle use the new active codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_valid | input | 1 | Control word strobe |
| ctrl_word | input | 16 | Control word |
| in_valid | input | 1 | Sample pair strobe |
| in_left | input | 16 | Left sample, two's complement |
| in_right | input | 16 | Right sample, two's complement |
| out_valid | output | 1 | Output pair strobe |
| out_left | output | 16 | Attenuated left sample |
| out_right | output | 16 | Attenuated right sample |

## Verification
The hardest case to reach from the ports is a committing word and a sample pair arriving in the same cycle, especially when the other channel holds a code staged earlier that has not been loaded yet. The bench drives this case directly, and the random phase also produces it often by asserting both strobes in one cycle. Negative samples with small codes check the floor rounding. Rejected words that carry a load flag check that a bad word cannot commit a pending staged code.

// File: rtl/stvol_pkg.sv
package stvol_pkg;
    localparam int WORD_W   = 16;
    localparam int SMP_W    = 16;
    localparam int CODE_W   = 8;
    localparam int NCH      = 2;
    localparam int ADDR_W   = 2;
    localparam int ADDR_LO  = 9;
    localparam int LOAD_BIT = 8;
    localparam int RSV_LO   = ADDR_LO + ADDR_W;
    localparam int PROD_W   = SMP_W + CODE_W + 1;

    typedef logic [CODE_W-1:0]        code_t;
    typedef logic signed [SMP_W-1:0]  smp_t;

    localparam code_t CODE_UNITY = '1;

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] chan;
        logic              load;
        code_t             code;
    } cmd_t;

    // Split a control word into fields and flag whether it is accepted.
    function automatic cmd_t decode_word(input logic [WORD_W-1:0] w, input logic v);
        cmd_t c;
        c.chan = w[ADDR_LO +: ADDR_W];
        c.load = w[LOAD_BIT];
        c.code = w[CODE_W-1:0];
        c.hit  = v && (w[WORD_W-1:RSV_LO] == '0) && (int'(c.chan) < NCH);
        return c;
    endfunction

    // Gain of code/256, with the all-ones code treated as unity.
    function automatic smp_t att_scale(input smp_t s, input code_t c);
        logic signed [PROD_W-1:0] se;
        logic signed [PROD_W-1:0] ce;
        logic signed [PROD_W-1:0] p;
        logic signed [PROD_W-1:0] sh;
        se = PROD_W'(s);
        ce = PROD_W'($signed({1'b0, c}));
        p  = se * ce;
        sh = p >>> CODE_W;
        if (c == CODE_UNITY) return s;
        return sh[SMP_W-1:0];
    endfunction
endpackage

// File: rtl/stvol_decode.sv
module stvol_decode
    import stvol_pkg::*;
(
    input  logic              valid,
    input  logic [WORD_W-1:0] word,
    output cmd_t              cmd
);
    always_comb cmd = decode_word(word, valid);
endmodule

// File: rtl/stvol_codes.sv
module stvol_codes
    import stvol_pkg::*;
#(
    parameter int N = NCH
) (
    input  logic                clk,
    input  logic                rst,
    input  cmd_t                cmd,
    output logic [N-1:0][CODE_W-1:0] staged,
    output logic [N-1:0][CODE_W-1:0] active
);
    for (genvar i = 0; i < N; i++) begin : g_ch
        code_t stg_q, act_q, stg_nxt;
        logic  sel;

        always_comb begin
            sel     = cmd.hit && (cmd.chan == ADDR_W'(i));
            stg_nxt = sel ? cmd.code : stg_q;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                stg_q <= CODE_UNITY;
                act_q <= CODE_UNITY;
            end else begin
                stg_q <= stg_nxt;
                if (cmd.hit && cmd.load) act_q <= stg_nxt;
            end
        end

        assign staged[i] = stg_q;
        assign active[i] = act_q;
    end
endmodule

// File: rtl/stvol_scale.sv
module stvol_scale
    import stvol_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  smp_t  din,
    input  code_t code,
    output smp_t  dout
);
    always_ff @(posedge clk) begin
        if (rst)     dout <= '0;
        else if (en) dout <= att_scale(din, code);
    end
endmodule

// File: rtl/stereo_vol_atten.sv
module stereo_vol_atten
    import stvol_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_valid,
    input  logic [WORD_W-1:0] ctrl_word,
    input  logic              in_valid,
    input  logic [SMP_W-1:0]  in_left,
    input  logic [SMP_W-1:0]  in_right,
    output logic              out_valid,
    output logic [SMP_W-1:0]  out_left,
    output logic [SMP_W-1:0]  out_right
);
    cmd_t cmd;
    logic [NCH-1:0][CODE_W-1:0] stg_code;
    logic [NCH-1:0][CODE_W-1:0] act_code;
    smp_t smp_in  [NCH];
    smp_t smp_out [NCH];

    stvol_decode u_dec (.valid(ctrl_valid), .word(ctrl_word), .cmd(cmd));

    stvol_codes #(.N(NCH)) u_codes (
        .clk(clk), .rst(rst), .cmd(cmd), .staged(stg_code), .active(act_code)
    );

    assign smp_in[0] = in_left;
    assign smp_in[1] = in_right;

    for (genvar i = 0; i < NCH; i++) begin : g_scl
        stvol_scale u_scl (
            .clk(clk), .rst(rst), .en(in_valid),
            .din(smp_in[i]), .code(act_code[i]), .dout(smp_out[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
    end

    assign out_left  = smp_out[0];
    assign out_right = smp_out[1];
endmodule

// File: rtl/stvol_chk.sv
module stvol_chk (
    input logic        clk,
    input logic        rst,
    input logic        ctrl_valid,
    input logic [15:0] ctrl_word,
    input logic        in_valid,
    input logic [15:0] in_left,
    input logic        out_valid,
    input logic [15:0] out_left,
    input logic [15:0] out_right,
    input logic [7:0]  act_l,
    input logic [7:0]  act_r,
    input logic [7:0]  stg_l,
    input logic [7:0]  stg_r
);
    logic bad_word;
    assign bad_word = ctrl_valid && ((ctrl_word[15:11] != 5'd0) || ctrl_word[10]);

    AST_OUT_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> (!out_valid && $stable(out_left) && $stable(out_right))); // R9
    AST_BAD_WORD_IGNORED: assert property (@(posedge clk) disable iff (rst) bad_word |=> ($stable(act_l) && $stable(act_r) && $stable(stg_l) && $stable(stg_r))); // R5
    AST_NO_LOAD_KEEPS_GAIN: assert property (@(posedge clk) disable iff (rst) !(ctrl_valid && ctrl_word[8]) |=> ($stable(act_l) && $stable(act_r))); // R2
    AST_LOAD_ALIGNS_BOTH: assert property (@(posedge clk) disable iff (rst) (ctrl_valid && ctrl_word[8] && ctrl_word[15:10] == 6'd0) |=> (act_l == stg_l && act_r == stg_r)); // R3
    AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (rst) (in_valid && act_l == 8'h00) |=> (out_left == 16'd0)); // R7
    AST_UNITY_PASS: assert property (@(posedge clk) disable iff (rst) (in_valid && act_l == 8'hFF) |=> (out_left == $past(in_left))); // R8
endmodule

bind stereo_vol_atten stvol_chk u_chk (
    .clk(clk), .rst(rst), .ctrl_valid(ctrl_valid), .ctrl_word(ctrl_word),
    .in_valid(in_valid), .in_left(in_left), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right),
    .act_l(act_code[0]), .act_r(act_code[1]), .stg_l(stg_code[0]), .stg_r(stg_code[1])
);

// File: tb/test_stereo_vol_atten.sv
`timescale 1ns/1ps
module test_stereo_vol_atten;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_valid = 1'b0;
    logic [15:0] ctrl_word = '0;
    logic        in_valid = 1'b0;
    logic [15:0] in_left = '0, in_right = '0;
    logic        out_valid;
    logic [15:0] out_left, out_right;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_stg [2];
    int m_act [2];
    logic [15:0] prev_l = '0, prev_r = '0;

    always #2.5 clk = ~clk;

    stereo_vol_atten i_stereo_vol_atten (
        .clk(clk), .rst(rst), .ctrl_valid(ctrl_valid), .ctrl_word(ctrl_word),
        .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
    );

    function automatic logic [15:0] ref_scale(input logic [15:0] s, input int code);
        int v, p, q;
        v = int'($signed(s));
        if (code == 255) return s;
        p = v * code;
        if (p >= 0) q = p / 256;
        else        q = -((-p + 255) / 256);
        return q[15:0];
    endfunction

    function automatic logic [15:0] mk_word(input int addr, input bit load, input int code);
        return {5'd0, addr[1:0], load, code[7:0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus: optional word, optional sample pair, then check.
    task automatic step(input string tag, input bit cv, input logic [15:0] w,
                        input bit sv, input logic [15:0] l, input logic [15:0] r);
        logic [15:0] el, er;
        int a;
        bit ok;
        @(negedge clk);
        ctrl_valid = cv; ctrl_word = w;
        in_valid = sv; in_left = l; in_right = r;
        el = sv ? ref_scale(l, m_act[0]) : prev_l;
        er = sv ? ref_scale(r, m_act[1]) : prev_r;
        a  = int'(w[10:9]);
        ok = cv && (w[15:11] == 5'd0) && (a < 2);
        if (ok) begin
            m_stg[a] = int'(w[7:0]);
            if (w[8]) begin m_act[0] = m_stg[0]; m_act[1] = m_stg[1]; end
        end
        @(negedge clk);
        ctrl_valid = 1'b0; in_valid = 1'b0;
        check({tag, " valid R9"}, 32'(out_valid), 32'(sv));
        check({tag, " left"},  32'(out_left),  32'(el));
        check({tag, " right"}, 32'(out_right), 32'(er));
        prev_l = el; prev_r = er;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_stg[0] = 255; m_stg[1] = 255; m_act[0] = 255; m_act[1] = 255;
        repeat (3) @(negedge clk);
        check("R1 reset valid", 32'(out_valid), 32'd0);
        check("R1 reset left", 32'(out_left), 32'd0);
        check("R1 reset right", 32'(out_right), 32'd0);
        rst = 1'b0;

        step("R1 R8 unity after reset", 0, '0, 1, 16'h8000, 16'h7FFF);
        step("R2 stage left no load", 1, mk_word(0, 0, 8'h80), 0, '0, '0);
        step("R2 gain unchanged", 0, '0, 1, 16'h1234, 16'h1234);
        step("R3 R4 load right commits both", 1, mk_word(1, 1, 8'h40), 0, '0, '0);
        step("R3 R4 new gains", 0, '0, 1, 16'h4000, 16'h4000);
        step("R6 negative floor", 0, '0, 1, 16'hFFFF, 16'hFFFD);
        step("R2 stage right", 1, mk_word(1, 0, 8'h20), 0, '0, '0);
        step("R5 reserved bit with load", 1, 16'h0900, 0, '0, '0);
        step("R5 address 2 with load", 1, 16'h0500, 0, '0, '0);
        step("R5 address 3 with load", 1, 16'h0700, 0, '0, '0);
        step("R5 gains unchanged", 0, '0, 1, 16'h4000, 16'h4000);
        step("R10 load with sample same cycle", 1, mk_word(0, 1, 8'h00), 1, 16'h4000, 16'h4000);
        step("R7 R10 mute and new right", 0, '0, 1, 16'h7FFF, 16'h4000);
        step("R9 idle hold", 0, '0, 0, 16'h5555, 16'h5555);
        step("R6 FE on full negative", 1, mk_word(1, 1, 8'hFE), 0, '0, '0);
        step("R6 FE sample", 0, '0, 1, 16'h8000, 16'h8000);
        step("R8 restore unity", 1, mk_word(0, 1, 8'hFF), 1, 16'h0101, 16'h0101);
        step("R8 unity left", 0, '0, 1, 16'hABCD, 16'hABCD);

        for (int i = 0; i < 400; i++) begin
            bit cv, sv;
            logic [15:0] w;
            cv = ($urandom % 3) == 0;
            sv = ($urandom % 4) != 0;
            case ($urandom % 8)
                0:       w = 16'($urandom);
                1:       w = mk_word(2 + int'($urandom % 2), 1'($urandom), int'($urandom % 256));
                default: w = mk_word(int'($urandom % 2), 1'($urandom), int'($urandom % 256));
            endcase
            step("R6 R10 random", cv, w, sv, 16'($urandom), 16'($urandom));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule